// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned operands of a parameterised width together with a single carry input. It returns the low bits of the result and the carry that leaves the top bit. Internally, every bit forms a generate term (both inputs set) and a propagate term (inputs differ). Each 4-bit slice resolves its own carries by lookahead and summarises itself as one group generate and one group propagate.

The same 4-input lookahead cell is reused a level up. There it combines four slice summaries into a 16-bit unit and supplies the carries into slices 1 to 3. Widths above 16 bits chain whole units through their unit-level generate and propagate.

The block also presents the word-level generate and propagate. A parent lookahead stage can use these to treat the whole adder as one group. The block has no clock and no state.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i`, taken as unsigned values.
- R2: `carry_o` equals bit WIDTH of `a_i + b_i + carry_i`. It also equals `grp_gen_o OR (grp_prop_o AND carry_i)`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i` with no carry in exceeds 2^WIDTH - 1.
- R4: `grp_prop_o` is 1 exactly when every bit of `a_i XOR b_i` is 1.
- R5: When every bit of `a_i XOR b_i` is 1, `carry_o` equals `carry_i`. In that case `sum_o` is all ones when `carry_i` is 0 and all zeros when `carry_i` is 1.
- R6: When `a_i OR b_i` is all zeros, `carry_o` is 0 and `sum_o` is `carry_i` in bit 0 with zeros above.
- R7: WIDTH must be a non-zero multiple of 16; any other value stops elaboration. A 16-bit instance meets R1 and R2 for every combination of low-byte operands and carry in, with the upper byte of the operands set to a full-propagate pattern.
- R8: `grp_gen_o` and `grp_prop_o` are never 1 at the same time.
- R9: The outputs depend only on the present inputs. With all inputs at zero, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned addend |
| b_i | input | WIDTH | Second unsigned addend |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the result |
| carry_o | output | 1 | Carry out of the top bit |
| grp_gen_o | output | 1 | Word-level generate: the word produces a carry by itself |
| grp_prop_o | output | 1 | Word-level propagate: the word passes its carry in straight through |

## Verification
The bound checker watches every input combination. It checks the following:
- the carry out agrees with the word-level generate and propagate and the carry in;
- generate and propagate are never 1 together;
- a full-propagate word passes the carry through;
- an all-kill word blocks it;
- bit 0 of the sum is the parity of its three inputs.

These are relations between separately built parts of the tree. Whether each inner carry lands in the right bit for realistic operands shows only in the bench. The bench runs a table of vectors, random operands compared against an arithmetic reference, and a swept low byte on a 16-bit instance. In that sweep, carries from the low slices must travel through every lookahead level to reach the carry out.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int GRP_W    = 4;
   localparam int UNIT_GRP = 4;
   localparam int UNIT_W   = GRP_W * UNIT_GRP;
endpackage

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
   input  logic [3:0] gen_i,
   input  logic [3:0] prop_i,
   input  logic       c0_i,
   output logic [3:1] carry_o,
   output logic       grp_gen_o,
   output logic       grp_prop_o
);
   always_comb begin
      carry_o[1] = gen_i[0] | (prop_i[0] & c0_i);
      carry_o[2] = gen_i[1] | (prop_i[1] & gen_i[0])
                 | (prop_i[1] & prop_i[0] & c0_i);
      carry_o[3] = gen_i[2] | (prop_i[2] & gen_i[1])
                 | (prop_i[2] & prop_i[1] & gen_i[0])
                 | (prop_i[2] & prop_i[1] & prop_i[0] & c0_i);
      grp_gen_o  = gen_i[3] | (prop_i[3] & gen_i[2])
                 | (prop_i[3] & prop_i[2] & gen_i[1])
                 | (prop_i[3] & prop_i[2] & prop_i[1] & gen_i[0]);
      grp_prop_o = &prop_i;
   end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
   import cla_pkg::*;
(
   input  logic [GRP_W-1:0] a_i,
   input  logic [GRP_W-1:0] b_i,
   input  logic             cin_i,
   output logic [GRP_W-1:0] sum_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);
   logic [GRP_W-1:0] bit_gen, bit_prop, bit_cin;
   logic [3:1]       la_carry;

   assign bit_gen  = a_i & b_i;
   assign bit_prop = a_i ^ b_i;

   cla_lookahead4 u_la (
      .gen_i      (bit_gen),
      .prop_i     (bit_prop),
      .c0_i       (cin_i),
      .carry_o    (la_carry),
      .grp_gen_o  (grp_gen_o),
      .grp_prop_o (grp_prop_o)
   );

   assign bit_cin = {la_carry, cin_i};
   assign sum_o   = bit_prop ^ bit_cin;
endmodule

// File: rtl/cla_unit16.sv
module cla_unit16
   import cla_pkg::*;
(
   input  logic [UNIT_W-1:0] a_i,
   input  logic [UNIT_W-1:0] b_i,
   input  logic              cin_i,
   output logic [UNIT_W-1:0] sum_o,
   output logic              unit_gen_o,
   output logic              unit_prop_o
);
   logic [UNIT_GRP-1:0] grp_gen, grp_prop, grp_cin;
   logic [3:1]          la_carry;

   for (genvar gi = 0; gi < UNIT_GRP; gi++) begin : g_grp
      cla_group4 u_grp (
         .a_i        (a_i[gi*GRP_W +: GRP_W]),
         .b_i        (b_i[gi*GRP_W +: GRP_W]),
         .cin_i      (grp_cin[gi]),
         .sum_o      (sum_o[gi*GRP_W +: GRP_W]),
         .grp_gen_o  (grp_gen[gi]),
         .grp_prop_o (grp_prop[gi])
      );
   end

   cla_lookahead4 u_la2 (
      .gen_i      (grp_gen),
      .prop_i     (grp_prop),
      .c0_i       (cin_i),
      .carry_o    (la_carry),
      .grp_gen_o  (unit_gen_o),
      .grp_prop_o (unit_prop_o)
   );

   assign grp_cin = {la_carry, cin_i};
endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);
   localparam int NUNIT = WIDTH / UNIT_W;

   if (WIDTH < UNIT_W || (WIDTH % UNIT_W) != 0) begin : g_bad_width
      $error("cla_adder: WIDTH must be a non-zero multiple of 16");
   end

   logic [NUNIT-1:0] unit_gen, unit_prop;
   logic [NUNIT:0]   unit_cin;
   logic [NUNIT:0]   acc_gen, acc_prop;

   assign unit_cin[0] = carry_i;
   assign acc_gen[0]  = 1'b0;
   assign acc_prop[0] = 1'b1;

   for (genvar ui = 0; ui < NUNIT; ui++) begin : g_unit
      cla_unit16 u_unit (
         .a_i         (a_i[ui*UNIT_W +: UNIT_W]),
         .b_i         (b_i[ui*UNIT_W +: UNIT_W]),
         .cin_i       (unit_cin[ui]),
         .sum_o       (sum_o[ui*UNIT_W +: UNIT_W]),
         .unit_gen_o  (unit_gen[ui]),
         .unit_prop_o (unit_prop[ui])
      );
      assign unit_cin[ui+1] = unit_gen[ui] | (unit_prop[ui] & unit_cin[ui]);
      assign acc_gen[ui+1]  = unit_gen[ui] | (unit_prop[ui] & acc_gen[ui]);
      assign acc_prop[ui+1] = unit_prop[ui] & acc_prop[ui];
   end

   assign carry_o    = unit_cin[NUNIT];
   assign grp_gen_o  = acc_gen[NUNIT];
   assign grp_prop_o = acc_prop[NUNIT];
endmodule

// File: rtl/cla_adder_checker.sv
module cla_adder_checker #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             carry_i,
   input logic [WIDTH-1:0] sum_o,
   input logic             carry_o,
   input logic             grp_gen_o,
   input logic             grp_prop_o
);
   logic known;
   assign known = !$isunknown({a_i, b_i, carry_i});

   always_comb begin
      if (known) begin
         p_cout_group_r2: assert (carry_o == (grp_gen_o | (grp_prop_o & carry_i)));
         p_gp_excl_r8: assert (!(grp_gen_o && grp_prop_o));
         p_lsb_sum_r1: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ carry_i));
         if (&(a_i ^ b_i)) begin
            p_full_prop_r5: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}});
         end
         if ((a_i | b_i) == '0) begin
            p_kill_r6: assert (!carry_o && sum_o == {{(WIDTH-1){1'b0}}, carry_i});
         end
      end
   end
endmodule

bind cla_adder cla_adder_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_adder_test.sv
module cla_adder_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] a32 = '0, b32 = '0, s32;
   logic        c32 = 1'b0, co32, g32, p32;
   logic [15:0] a16 = '0, b16 = '0, s16;
   logic        c16 = 1'b0, co16, g16, p16;

   cla_adder #(.WIDTH(32)) uut (
      .a_i(a32), .b_i(b32), .carry_i(c32), .sum_o(s32),
      .carry_o(co32), .grp_gen_o(g32), .grp_prop_o(p32));

   cla_adder #(.WIDTH(16)) uut16 (
      .a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s16),
      .carry_o(co16), .grp_gen_o(g16), .grp_prop_o(p16));

   // row layout: {a, b, cin, sum, cout, gen, prop}
   localparam int NVEC = 9;
   localparam logic [99:0] VEC [NVEC] = '{
      {32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
      {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
      {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
      {32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1},
      {32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
      {32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
      {32'h1234_5678, 32'h1111_1111, 1'b0, 32'h2345_6789, 1'b0, 1'b0, 1'b0},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0},
      {32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'h0001_0000, 1'b0, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
      @(posedge clk);
      a32 = a; b32 = b; c32 = c;
      @(negedge clk);
   endtask

   // full arithmetic check of the 32-bit instance against a reference sum
   task automatic ref_check32(input string tag);
      logic [32:0] r, r0, r1;
      r  = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
      r0 = {1'b0, a32} + {1'b0, b32};
      r1 = r0 + 33'd1;
      check(s32 == r[31:0], "R1", {tag, " sum"}, {32'd0, s32}, {32'd0, r[31:0]});
      check(co32 == r[32], "R2", {tag, " cout"}, {63'd0, co32}, {63'd0, r[32]});
      check(g32 == r0[32], "R3", {tag, " gen"}, {63'd0, g32}, {63'd0, r0[32]});
      check(p32 == (&(a32 ^ b32)), "R4", {tag, " prop"}, {63'd0, p32},
            {63'd0, &(a32 ^ b32)});
      check((g32 | p32) == r1[32], "R4", {tag, " gen|prop"}, {63'd0, g32 | p32},
            {63'd0, r1[32]});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R9: idle state with every input at zero
      @(negedge clk);
      check({s32, co32, g32, p32} == '0, "R9", "idle 32", {29'd0, s32, co32, g32, p32}, 64'd0);
      check({s16, co16, g16, p16} == '0, "R9", "idle 16", {45'd0, s16, co16, g16, p16}, 64'd0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         drive32(VEC[i][99:68], VEC[i][67:36], VEC[i][35]);
         check(s32 == VEC[i][34:3], "R1", "table sum", {32'd0, s32}, {32'd0, VEC[i][34:3]});
         check(co32 == VEC[i][2], "R2", "table cout", {63'd0, co32}, {63'd0, VEC[i][2]});
         check(g32 == VEC[i][1], "R3", "table gen", {63'd0, g32}, {63'd0, VEC[i][1]});
         check(p32 == VEC[i][0], "R4", "table prop", {63'd0, p32}, {63'd0, VEC[i][0]});
         check(!(g32 && p32), "R8", "table gen/prop exclusive", {62'd0, g32, p32}, 64'd0);
      end

      // R5: full propagate with both carry values
      for (int c = 0; c < 2; c++) begin
         drive32(32'h0F0F_3C3C, 32'hF0F0_C3C3, c[0]);
         check(co32 == c[0], "R5", "propagate cout", {63'd0, co32}, {63'd0, c[0]});
         check(s32 == {32{~c[0]}}, "R5", "propagate sum", {32'd0, s32}, {32'd0, {32{~c[0]}}});
      end

      // R6: all-kill word
      for (int c = 0; c < 2; c++) begin
         drive32(32'd0, 32'd0, c[0]);
         check(co32 == 1'b0, "R6", "kill cout", {63'd0, co32}, 64'd0);
         check(s32 == {31'd0, c[0]}, "R6", "kill sum", {32'd0, s32}, {63'd0, c[0]});
      end

      // R1..R4: random operands, plus carries crossing the 16-bit seam
      for (int i = 0; i < 1500; i++) begin
         drive32($urandom, $urandom, 1'($urandom));
         ref_check32("random");
      end
      for (int i = 0; i < 64; i++) begin
         drive32({16'($urandom), 16'hFFFF}, {16'($urandom), 16'd0}, 1'b1);
         ref_check32("seam");
      end

      // R7: 16-bit instance, low byte swept with carry in, upper byte full propagate
      for (int v = 0; v < 131072; v++) begin
         logic [16:0] r;
         @(posedge clk);
         a16 = {8'h5A, v[7:0]};
         b16 = {8'hA5, v[15:8]};
         c16 = v[16];
         @(negedge clk);
         r = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
         check(s16 == r[15:0], "R7", "w16 sum", {48'd0, s16}, {48'd0, r[15:0]});
         check(co16 == r[16], "R7", "w16 cout", {63'd0, co16}, {63'd0, r[16]});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule